// File: doc/BRIEF.md
# Hardened Boot Sequencing Controller

This controller takes a chip out of cold reset and steps it through a fixed bring-up order. It enables fuse loading and waits until loading finishes. It then issues a single-cycle firmware reset and waits for a go indication. Finally it settles in a terminal operational state. The state is held in a 3-bit register with five named codes. Every one of the eight bit patterns has a defined successor.

The three unnamed patterns (5, 6, 7) can still appear through an upset or a glitch on reset release. When one appears, the machine returns to IDLE on the next clock and raises a sticky error flag. That flag clears only on reset. After recovery the machine restarts the boot order from the beginning. All outputs come from flops and are decoded from the next state, so each output changes in the same cycle as the state it belongs to.

Top module: `boot_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (IDLE) and `fuse_en_o`, `fw_rst_o`, `boot_done_o` and `illegal_err_o` are all 0.
- R2: On the first rising clock edge after `rst_n` goes high, the state moves from IDLE (0) to FUSE (1), and `fuse_en_o` rises in the same cycle.
- R3: In FUSE (1) the machine holds while `fuse_done_i` is low. A rising edge that samples `fuse_done_i` high moves it to FW_RST (2).
- R4: FW_RST (2) lasts exactly one cycle and then moves to WAIT (3). `fw_rst_o` is high only during that cycle.
- R5: In WAIT (3), `fw_req_i` high moves to FW_RST (2) and takes priority over `go_i`. Otherwise `go_i` high moves to DONE (4). Otherwise the machine holds.
- R6: DONE (4) is terminal until reset. `boot_done_o` stays high and none of the inputs has any effect on it.
- R7: If the state register holds 5, 6 or 7, the next rising edge puts it in IDLE (0) and sets `illegal_err_o`.
- R8: `illegal_err_o` stays set until reset clears it. After a recovery, the machine follows the normal order again (IDLE to FUSE on the next edge).
- R9: Outputs are registered. Whenever the state is a named code, `fuse_en_o`, `fw_rst_o` and `boot_done_o` are high exactly in FUSE, FW_RST and DONE respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fuse_done_i | input | 1 | Fuse loading finished |
| fw_req_i | input | 1 | Request to repeat the firmware reset while waiting |
| go_i | input | 1 | Permission to enter operation |
| state_o | output | 3 | Current state code |
| fuse_en_o | output | 1 | Fuse loading enable |
| fw_rst_o | output | 1 | One-cycle firmware reset pulse |
| boot_done_o | output | 1 | Boot complete |
| illegal_err_o | output | 1 | Sticky flag: an unnamed state code was seen |

## Verification
The embedded properties are checked on every cycle. They cover recovery from any unnamed code to IDLE with the flag set, the flag staying set, holding in FUSE and DONE, the length of the firmware-reset pulse, and agreement between each output and the state. Some behaviour can only be shown by the bench scenarios. These are the exact boot order, the priority of a firmware-reset request over go, the clearing of the error flag by reset, and the restart after a recovery. The bench shows recovery from each of the three unnamed codes by forcing each one into the state register from a different phase of the boot.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;
  localparam int unsigned STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    BS_IDLE  = 3'd0,
    BS_FUSE  = 3'd1,
    BS_FWRST = 3'd2,
    BS_WAIT  = 3'd3,
    BS_DONE  = 3'd4
  } bs_state_e;

  typedef struct packed {
    logic fuse_en;
    logic fw_rst;
    logic done;
  } bs_outs_t;

  // True for the five named codes only.
  function automatic logic bs_is_named(input logic [STATE_W-1:0] s);
    return (s <= 3'(BS_DONE));
  endfunction

  // Output pattern of a state; unnamed codes drive all outputs low.
  function automatic bs_outs_t bs_decode(input logic [STATE_W-1:0] s);
    bs_outs_t o;
    o.fuse_en = (s == 3'(BS_FUSE));
    o.fw_rst  = (s == 3'(BS_FWRST));
    o.done    = (s == 3'(BS_DONE));
    return o;
  endfunction
endpackage

// File: rtl/boot_next_state.sv
`timescale 1ns/1ps
module boot_next_state
  import boot_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_q,
  input  logic               fuse_done_i,
  input  logic               fw_req_i,
  input  logic               go_i,
  output logic [STATE_W-1:0] state_d,
  output logic               illegal_o
);
  assign illegal_o = !bs_is_named(state_q);

  always_comb begin
    case (state_q)
      3'(BS_IDLE):  state_d = 3'(BS_FUSE);
      3'(BS_FUSE):  state_d = fuse_done_i ? 3'(BS_FWRST) : 3'(BS_FUSE);
      3'(BS_FWRST): state_d = 3'(BS_WAIT);
      3'(BS_WAIT): begin
        if (fw_req_i)  state_d = 3'(BS_FWRST);
        else if (go_i) state_d = 3'(BS_DONE);
        else           state_d = 3'(BS_WAIT);
      end
      3'(BS_DONE):  state_d = 3'(BS_DONE);
      default:      state_d = 3'(BS_IDLE);
    endcase
  end

  // R3: FUSE holds without fuse_done (unless an upset replaces the code)
  p_fuse_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(BS_FUSE) && !fuse_done_i) |=> (state_q == 3'(BS_FUSE) || illegal_o));

  // R4: FW_RST lasts one cycle, then WAIT
  p_fwrst_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(BS_FWRST)) |=> (state_q == 3'(BS_WAIT) || illegal_o));

  // R6: DONE is terminal
  p_done_terminal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(BS_DONE)) |=> (state_q == 3'(BS_DONE) || illegal_o));

  // R7: unnamed code recovers to IDLE on the next edge
  p_illegal_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> (state_q == 3'(BS_IDLE)));
endmodule

// File: rtl/boot_out_reg.sv
`timescale 1ns/1ps
module boot_out_reg
  import boot_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_d,
  output bs_outs_t           outs_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outs_q <= '0;
    else        outs_q <= bs_decode(state_d);
  end

  // R4: the firmware-reset pulse is never longer than one cycle
  p_fw_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    outs_q.fw_rst |=> !outs_q.fw_rst);

  // R9: at most one phase output is active
  p_outs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({outs_q.fuse_en, outs_q.fw_rst, outs_q.done}));
endmodule

// File: rtl/boot_err_latch.sv
`timescale 1ns/1ps
module boot_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic illegal_i,
  output logic err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (illegal_i) err_q <= 1'b1;
  end

  // R8: flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7: an unnamed code sets the flag on the next edge
  p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_i |=> err_q);
endmodule

// File: rtl/boot_seq_ctrl.sv
`timescale 1ns/1ps
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fuse_done_i,
  input  logic               fw_req_i,
  input  logic               go_i,
  output logic [STATE_W-1:0] state_o,
  output logic               fuse_en_o,
  output logic               fw_rst_o,
  output logic               boot_done_o,
  output logic               illegal_err_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic               illegal_w;
  bs_outs_t           outs_q;

  boot_next_state u_next (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .fuse_done_i (fuse_done_i),
    .fw_req_i    (fw_req_i),
    .go_i        (go_i),
    .state_d     (state_d),
    .illegal_o   (illegal_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 3'(BS_IDLE);
    else        state_q <= state_d;
  end

  boot_out_reg u_outs (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .outs_q  (outs_q)
  );

  boot_err_latch u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .illegal_i (illegal_w),
    .err_q     (illegal_err_o)
  );

  assign state_o     = state_q;
  assign fuse_en_o   = outs_q.fuse_en;
  assign fw_rst_o    = outs_q.fw_rst;
  assign boot_done_o = outs_q.done;

  // R9: registered outputs agree with the named state
  p_outs_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_w |-> (fuse_en_o == (state_q == 3'(BS_FUSE)) &&
                    fw_rst_o  == (state_q == 3'(BS_FWRST)) &&
                    boot_done_o == (state_q == 3'(BS_DONE))));

  // R2: IDLE is left on the next edge
  p_idle_leaves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 3'(BS_IDLE)) |=> (state_q == 3'(BS_FUSE) || illegal_w));
endmodule

// File: tb/tb_boot_seq_ctrl.sv
`timescale 1ns/1ps
module tb_boot_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fuse_done_i = 1'b0;
  logic       fw_req_i = 1'b0;
  logic       go_i = 1'b0;
  logic [2:0] state_o;
  logic       fuse_en_o, fw_rst_o, boot_done_o, illegal_err_o;

  always #2.5 clk = ~clk;

  boot_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .fuse_done_i(fuse_done_i), .fw_req_i(fw_req_i),
    .go_i(go_i), .state_o(state_o), .fuse_en_o(fuse_en_o), .fw_rst_o(fw_rst_o),
    .boot_done_o(boot_done_o), .illegal_err_o(illegal_err_o)
  );

  typedef struct {
    logic [2:0] st;
    logic       fe, fw, dn, er;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   ended = 0;
  logic [2:0] m_st = 3'd0;
  logic       m_er = 1'b0;

  function automatic logic [2:0] ref_next(input logic [2:0] s, input logic fd,
                                          input logic fr, input logic g);
    if (s == 3'd0) return 3'd1;
    if (s == 3'd1) return fd ? 3'd2 : 3'd1;
    if (s == 3'd2) return 3'd3;
    if (s == 3'd3) return fr ? 3'd2 : (g ? 3'd4 : 3'd3);
    if (s == 3'd4) return 3'd4;
    return 3'd0;
  endfunction

  task automatic compare(input exp_t e);
    n_chk++;
    if (state_o !== e.st || fuse_en_o !== e.fe || fw_rst_o !== e.fw ||
        boot_done_o !== e.dn || illegal_err_o !== e.er) begin
      n_bad++;
      $display("FAIL %s: got st=%0d fe=%b fw=%b dn=%b er=%b, exp st=%0d fe=%b fw=%b dn=%b er=%b",
               e.tag, state_o, fuse_en_o, fw_rst_o, boot_done_o, illegal_err_o,
               e.st, e.fe, e.fw, e.dn, e.er);
    end
  endtask

  // Predict the next cycle from the bench's own model and queue it
  task automatic push_next(input string tag);
    exp_t e;
    logic [2:0] ns;
    ns = ref_next(m_st, fuse_done_i, fw_req_i, go_i);
    if (m_st > 3'd4) m_er = 1'b1;
    m_st = ns;
    e.st = ns; e.fe = (ns == 3'd1); e.fw = (ns == 3'd2); e.dn = (ns == 3'd4);
    e.er = m_er; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(input logic fd, input logic fr, input logic g, input string tag);
    @(negedge clk);
    fuse_done_i = fd; fw_req_i = fr; go_i = g;
    push_next(tag);
    @(posedge clk);
  endtask

  // Upset the state register with an unnamed code for one edge
  task automatic inject(input logic [2:0] code, input string tag);
    @(negedge clk);
    force dut.state_q = code;
    #1;
    release dut.state_q;
    fuse_done_i = 1'b0; fw_req_i = 1'b0; go_i = 1'b0;
    m_st = code;
    push_next(tag);
    @(posedge clk);
  endtask

  task automatic reset_check(input string tag);
    exp_t e;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    e.st = 3'd0; e.fe = 0; e.fw = 0; e.dn = 0; e.er = 0; e.tag = tag;
    compare(e);
    m_st = 3'd0; m_er = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compare just after each edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, exp completion");
    finish_run();
  end

  initial begin
    exp_t e;
    #1;
    e.st = 3'd0; e.fe = 0; e.fw = 0; e.dn = 0; e.er = 0; e.tag = "R1 reset state";
    repeat (2) @(posedge clk);
    #1 compare(e);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    // rst released at negedge: first edge goes IDLE->FUSE (model starts in IDLE)
    e.st = 3'd1; e.fe = 1; e.tag = "R2 idle to fuse";
    #1 compare(e);
    m_st = 3'd1;

    step(0, 0, 0, "R3 fuse hold");
    step(0, 1, 1, "R3 fuse hold other inputs");
    step(1, 0, 0, "R3 fuse done to fw_rst");
    step(0, 0, 0, "R4 fw_rst to wait");
    step(0, 0, 0, "R5 wait hold");
    step(0, 1, 1, "R5 fw_req priority");
    step(0, 0, 1, "R4 pulse ends, R5 wait");
    step(0, 0, 1, "R5 go to done");
    step(1, 1, 0, "R6 done ignores inputs");
    step(0, 0, 1, "R6 done holds");
    step(1, 1, 1, "R9 done outputs");

    inject(3'd5, "R7 code 5 recovery");
    step(0, 0, 0, "R8 restart, flag sticky");
    step(1, 0, 0, "R8 flag sticky in fw_rst");
    inject(3'd6, "R7 code 6 recovery");
    step(0, 0, 0, "R8 restart after 6");
    step(0, 0, 0, "R9 fuse outputs after recovery");
    inject(3'd7, "R7 code 7 recovery");
    step(0, 0, 0, "R8 restart after 7");

    @(posedge clk); #2;
    reset_check("R8 reset clears flag, R1");
    @(posedge clk);
    #1;
    e.st = 3'd1; e.fe = 1; e.fw = 0; e.dn = 0; e.er = 0; e.tag = "R2 second boot";
    compare(e);
    m_st = 3'd1;
    step(1, 0, 0, "R3 second boot fw_rst");
    step(0, 0, 1, "R4 second boot wait");
    step(0, 0, 1, "R5 second boot done");
    step(0, 0, 0, "R6 second boot done hold");
    @(posedge clk); #2;
    finish_run();
  end
endmodule